// File: doc/BRIEF.md
# Power-Down Sequencer with Interrupt and Reset Wake

This block controls the deepest low-power state of a small 8-bit controller core. Software asks for power-down by writing a control byte with the request bit set. From the next cycle the block withdraws the core clock enable and drops the oscillator enable. The sequencer then waits, with all clocks frozen, until one of two things happens. The first is a qualified wake interrupt: an active-low pin that is enabled, set to level mode and marked top priority. The second is the reset input.

The interrupt wake qualifier is purely combinational, so it can raise the oscillator enable while the core clock is still stopped. The sequencer then enters a restart phase. There it counts a programmable number of stabilisation cycles on the free-running restart clock. For an interrupt wake it also waits until the waking pin reads high again through a two-flop synchroniser. Only then does it return the clock to the core.

On the first running cycle it gives a one-cycle resume pulse with a resume-type bit, so the core knows whether to service the interrupt or to continue after reset. Reset clears the power-down state asynchronously and also passes through the restart phase before the core runs.

Top module: `pmu_pd_ctrl`

## Requirements
- R1: While `rst` is high, `clk_en` and `pd_flag` are 0. After `rst` falls the block finishes a restart phase and then runs with `clk_en` = 1.
- R2: In the running state, a write (`reg_we` = 1) whose data bit 1 is 1 makes `pd_flag` = 1, `clk_en` = 0 and `osc_en` = 0 from the next cycle.
- R3: A write whose data bit 1 is 0 leaves the block running: `clk_en` stays 1 and `pd_flag` stays 0.
- R4: In power-down, when a qualified pin goes low, `osc_en` goes to 1 in the same cycle, with no clock edge needed. A pin is qualified when its enable, level-mode and top-priority bits are all 1.
- R5: A pin that is low in power-down does not wake the block if its enable bit is 0, or its level-mode bit is 0 (edge mode), or its priority bit is 0. In that case `osc_en` stays 0 and `pd_flag` stays 1.
- R6: The restart phase lasts `stab_cycles` + 1 cycles after an interrupt wake once the pin is already high. After `rst` falls it lasts `stab_cycles` cycles. `stab_cycles` = 0 is allowed.
- R7: After an interrupt wake the core clock stays off while the waking pin is held low. `clk_en` rises on the third sample after the pin is released, because of the two synchroniser stages plus one state update.
- R8: When the core clock returns, `resume_valid` is 1 for exactly one cycle. `resume_type` is 0 after an interrupt wake and 1 after a reset.
- R9: When `rst` rises during power-down, `pd_flag` clears at once, without waiting for a clock edge.
- R10: Either interrupt pin (index 0 or 1) can wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running restart clock |
| rst | input | 1 | Asynchronous active-high reset and wake source |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data; bit 1 requests power-down |
| irq_en | input | 2 | Per-pin interrupt enable |
| irq_level | input | 2 | Per-pin level-mode select (1 = level) |
| irq_hipri | input | 2 | Per-pin top-priority flag |
| irq_n | input | 2 | Active-low external interrupt pins |
| stab_cycles | input | 16 | Oscillator stabilisation cycle count |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Core and peripheral clock enable |
| pd_flag | output | 1 | Power-down bit state |
| resume_valid | output | 1 | One-cycle pulse when the core clock returns |
| resume_type | output | 1 | 0 = interrupt wake, 1 = reset wake |

## Verification
The assertions assume the configuration bits and `stab_cycles` stay constant during a restart phase. They also assume a waking pin stays low for at least one full clock period, so the clocked wake decision sees it. The stimulus changes configuration only in the running or power-down states, and never during a restart. Each wake pulse it drives is held low across at least one rising edge. All inputs change on falling edges, so a rising edge never meets an input in transition.

// File: rtl/pmu_pd_pkg.sv
package pmu_pd_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_RESTART = 2'd2
    } pmu_state_e;

endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Each pin gets its own register chain; the reset value is 1 (pin idle).
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or posedge rst) begin
            if (rst) chain_q <= '1;
            else     chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/pmu_wake_qual.sv
module pmu_wake_qual #(
    parameter int N_IRQ = 2
) (
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_level,
    input  logic [N_IRQ-1:0] irq_hipri,
    input  logic [N_IRQ-1:0] irq_n,
    output logic [N_IRQ-1:0] wake_vec,
    output logic             wake_any
);
    // A pin can wake the block only when all three configuration bits are set.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_pin
        assign wake_vec[g] = irq_en[g] & irq_level[g] & irq_hipri[g] & ~irq_n[g];
    end
    assign wake_any = |wake_vec;
endmodule

// File: rtl/pmu_stab_timer.sv
module pmu_stab_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q >= limit);

    // The count saturates at the limit, so done stays set until cleared.
    always_comb begin
        cnt_d = cnt_q;
        if (clear)             cnt_d = '0;
        else if (run && !done) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmu_pd_ctrl.sv
module pmu_pd_ctrl
    import pmu_pd_pkg::*;
#(
    parameter int N_IRQ    = 2,
    parameter int DATA_W   = 8,
    parameter int PD_BIT   = 1,
    parameter int CNT_W    = 16,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_IRQ-1:0]  irq_level,
    input  logic [N_IRQ-1:0]  irq_hipri,
    input  logic [N_IRQ-1:0]  irq_n,
    input  logic [CNT_W-1:0]  stab_cycles,
    output logic              osc_en,
    output logic              clk_en,
    output logic              pd_flag,
    output logic              resume_valid,
    output logic              resume_type
);
    typedef struct packed {
        pmu_state_e       state;
        logic             by_reset;
        logic [N_IRQ-1:0] mask;
        logic             rv;
        logic             rt;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic [N_IRQ-1:0] wake_vec;
    logic             wake_any;
    logic [N_IRQ-1:0] irq_sync;
    logic             tmr_clear, tmr_run, tmr_done;

    pmu_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
        .irq_en    (irq_en),
        .irq_level (irq_level),
        .irq_hipri (irq_hipri),
        .irq_n     (irq_n),
        .wake_vec  (wake_vec),
        .wake_any  (wake_any)
    );

    pmu_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (irq_n),
        .dout (irq_sync)
    );

    pmu_stab_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .run   (tmr_run),
        .limit (stab_cycles),
        .done  (tmr_done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rv  = 1'b0;
        tmr_clear = 1'b1;
        tmr_run   = 1'b0;
        case (ctl_q.state)
            ST_RUN: begin
                if (reg_we && reg_wdata[PD_BIT]) ctl_d.state = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_any) begin
                    ctl_d.state    = ST_RESTART;
                    ctl_d.mask     = wake_vec;
                    ctl_d.by_reset = 1'b0;
                end
            end
            ST_RESTART: begin
                tmr_clear = 1'b0;
                tmr_run   = 1'b1;
                // Leave only when the count is done and every waking pin reads high.
                if (tmr_done && ((irq_sync & ctl_q.mask) == ctl_q.mask)) begin
                    ctl_d.state = ST_RUN;
                    ctl_d.rv    = 1'b1;
                    ctl_d.rt    = ctl_q.by_reset;
                    tmr_clear   = 1'b1;
                end
            end
            default: ctl_d.state = ST_RESTART;
        endcase
    end

    // Reset puts the block into restart marked as a reset wake, which clears power-down at once.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ctl_q.state    <= ST_RESTART;
            ctl_q.by_reset <= 1'b1;
            ctl_q.mask     <= '0;
            ctl_q.rv       <= 1'b0;
            ctl_q.rt       <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clk_en       = (ctl_q.state == ST_RUN);
    assign pd_flag      = (ctl_q.state == ST_SLEEP);
    assign osc_en       = (ctl_q.state != ST_SLEEP) || wake_any;
    assign resume_valid = ctl_q.rv;
    assign resume_type  = ctl_q.rt;
endmodule

// File: rtl/pmu_pd_ctrl_chk.sv
module pmu_pd_ctrl_chk #(
    parameter int N_IRQ  = 2,
    parameter int DATA_W = 8,
    parameter int PD_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [N_IRQ-1:0]  irq_en,
    input logic [N_IRQ-1:0]  irq_level,
    input logic [N_IRQ-1:0]  irq_hipri,
    input logic [N_IRQ-1:0]  irq_n,
    input logic              osc_en,
    input logic              clk_en,
    input logic              pd_flag,
    input logic              resume_valid
);
    logic qualified;
    assign qualified = |(irq_en & irq_level & irq_hipri & ~irq_n);

    assert_pd_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_en && reg_we && reg_wdata[PD_BIT]) |=> (pd_flag && !clk_en));

    assert_no_false_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (pd_flag && !qualified) |=> pd_flag);

    assert_sleep_gates_R2: assert property (@(posedge clk) disable iff (rst)
        pd_flag |-> !clk_en);

    assert_osc_off_R4: assert property (@(posedge clk) disable iff (rst)
        (pd_flag && !qualified) |-> !osc_en);

    assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        resume_valid |=> !resume_valid);

    assert_resume_on_return_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> resume_valid);

    assert_run_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !(reg_we && reg_wdata[PD_BIT])) |=> clk_en);
endmodule

bind pmu_pd_ctrl pmu_pd_ctrl_chk #(
    .N_IRQ  (N_IRQ),
    .DATA_W (DATA_W),
    .PD_BIT (PD_BIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .irq_en       (irq_en),
    .irq_level    (irq_level),
    .irq_hipri    (irq_hipri),
    .irq_n        (irq_n),
    .osc_en       (osc_en),
    .clk_en       (clk_en),
    .pd_flag      (pd_flag),
    .resume_valid (resume_valid)
);

// File: tb/pmu_pd_ctrl_tb.sv
`timescale 1ns/1ps
module pmu_pd_ctrl_tb;
    localparam int STAB = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  irq_en = '0, irq_level = '0, irq_hipri = '0;
    logic [1:0]  irq_n = 2'b11;
    logic [15:0] stab_cycles = 16'(STAB);
    logic        osc_en, clk_en, pd_flag, resume_valid, resume_type;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];

    always #10 clk = ~clk;

    pmu_pd_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .irq_en(irq_en), .irq_level(irq_level), .irq_hipri(irq_hipri),
        .irq_n(irq_n), .stab_cycles(stab_cycles), .osc_en(osc_en),
        .clk_en(clk_en), .pd_flag(pd_flag), .resume_valid(resume_valid),
        .resume_type(resume_type)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected resume type for every resume pulse.
    always @(negedge clk) begin
        if (!rst && resume_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected resume pulse", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(resume_type == e, "R8 resume_type", int'(resume_type), int'(e));
            end
        end
    end

    task automatic wait_run(input int exp_zero, input string tag);
        int cnt = 0;
        while (cnt < 1000) begin
            @(negedge clk);
            if (clk_en) break;
            cnt++;
        end
        check(cnt == exp_zero, tag, cnt, exp_zero);
    endtask

    task automatic enter_pd();
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
        check(pd_flag == 1'b1, "R2 pd_flag set", int'(pd_flag), 1);
        check(clk_en == 1'b0, "R2 clk_en off", int'(clk_en), 0);
        check(osc_en == 1'b0, "R2 osc_en off", int'(osc_en), 0);
    endtask

    task automatic try_bad(input logic en, input logic lvl, input logic hi, input string tag);
        irq_en = {1'b0, en}; irq_level = {1'b0, lvl}; irq_hipri = {1'b0, hi};
        irq_n[0] = 1'b0;
        repeat (8) @(negedge clk);
        check(osc_en == 1'b0, tag, int'(osc_en), 0);
        check(pd_flag == 1'b1, tag, int'(pd_flag), 1);
        irq_n[0] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(clk_en == 1'b0, "R1 clk_en in reset", int'(clk_en), 0);
        check(pd_flag == 1'b0, "R1 pd_flag in reset", int'(pd_flag), 0);
        exp_q.push_back(1'b1);
        rst = 1'b0;
        wait_run(STAB, "R1 R6 restart after reset");

        // R3: write without the request bit
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 8'hFD;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
        @(negedge clk);
        check(clk_en == 1'b1, "R3 still running", int'(clk_en), 1);
        check(pd_flag == 1'b0, "R3 no power-down", int'(pd_flag), 0);

        // R5: unqualified pins must not wake
        enter_pd();
        try_bad(1'b0, 1'b1, 1'b1, "R5 disabled pin");
        try_bad(1'b1, 1'b0, 1'b1, "R5 edge-mode pin");
        try_bad(1'b1, 1'b1, 1'b0, "R5 low-priority pin");

        // R4 R6: qualified short pulse on pin 0
        irq_en = 2'b01; irq_level = 2'b01; irq_hipri = 2'b01;
        exp_q.push_back(1'b0);
        irq_n[0] = 1'b0;
        #1;
        check(osc_en == 1'b1, "R4 osc_en async", int'(osc_en), 1);
        @(negedge clk);
        irq_n[0] = 1'b1;
        begin
            int cnt = 1;
            while (cnt < 1000) begin
                @(negedge clk);
                if (clk_en) break;
                cnt++;
            end
            check(cnt == STAB + 1, "R6 restart after irq wake", cnt, STAB + 1);
        end
        check(pd_flag == 1'b0, "R4 pd cleared", int'(pd_flag), 0);

        // R7 R10: pin 1 held low
        enter_pd();
        irq_en = 2'b10; irq_level = 2'b10; irq_hipri = 2'b10;
        exp_q.push_back(1'b0);
        irq_n[1] = 1'b0;
        #1;
        check(osc_en == 1'b1, "R10 pin1 wakes osc", int'(osc_en), 1);
        repeat (20) @(negedge clk);
        check(clk_en == 1'b0, "R7 held while pin low", int'(clk_en), 0);
        irq_n[1] = 1'b1;
        wait_run(2, "R7 release latency");

        // R9: reset in power-down, with stab_cycles 0 for the R6 boundary
        enter_pd();
        stab_cycles = '0;
        #1;
        rst = 1'b1;
        #1;
        check(pd_flag == 1'b0, "R9 async clear", int'(pd_flag), 0);
        exp_q.push_back(1'b1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wait_run(0, "R6 zero stab after reset");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8 all resumes seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule